// File: doc/BRIEF.md
# Stream FIFO with Width Packing and Threshold Bursts

This block sits between the peripheral side and the memory side of one transfer stream. Peripheral items arrive as bytes, halfwords or words, each with its own size code. The block forwards them to memory in one of two ways.

In pass-through mode each accepted item is held in a single register and offered to memory at once as a single transfer. The 16-byte store is not used, and the item's width must match the configured memory width. In buffered mode the items are packed into 32-bit words in a 16-byte store. A burst is requested once the fill level reaches a selectable threshold.

A loadable count of remaining items paces the stream. A sticky error flag reports two cases: an item whose width does not match in pass-through mode, and a stream whose last bytes can never reach the burst threshold.

Top module: `dma_stream_fifo`

## Requirements
- R1: After reset, `cnt` is 0, and `per_ready`, `mem_single`, `mem_burst_req` and `err_flag` are all 0.
- R2: A pulse on `cnt_load` sets `cnt` to `cnt_init`. `cnt` then drops by exactly one for each accepted item whose width is legal. It holds its value while no item is accepted.
- R3: `per_ready` is 0 whenever `cnt` is 0.
- R4: Pass-through mode (`cfg_fifo_en`=0). An accepted item appears one clock later on `mem_single`=1, with `mem_data` masked to its size and `mem_size` equal to its size code. Size codes are 0=byte, 1=halfword, 2=word. The item, and the low `per_ready` that goes with it, stay in place until the clock in which `mem_ack` is 1.
- R5: In pass-through mode, an accepted item whose `per_size` differs from `cfg_msize` is dropped. `mem_single` stays 0, `cnt` is unchanged, and `err_flag` becomes 1 one clock later.
- R6: In buffered mode, items are packed into 32-bit words in little-endian lane order. The first byte received lands in bits [7:0], and a halfword fills two consecutive lanes, low byte first.
- R7: In buffered mode, `cfg_thresh` selects a threshold of 4 bytes (0), 8 bytes (1), 12 bytes (2) or 16 bytes (3). A burst of (`cfg_thresh`+1) words is requested once the fill reaches the threshold, and not before. At the start of the burst, `mem_beats_left` shows that word count.
- R8: The store holds 16 bytes. `per_ready` is 0 when the offered item does not fit in the free space.
- R9: In buffered mode, if `cnt` is 0 and no burst is active while 1 to threshold-1 bytes remain, `err_flag` is set and those bytes are discarded. A stream that ends on an exact multiple of the threshold sets no error.
- R10: `err_flag` stays 1 until a clock in which `err_clr` is 1.
- R11: During a burst, `mem_data` shows the oldest stored word. Each clock with `mem_ack`=1 pops one word and decrements `mem_beats_left`. The burst ends after the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fifo_en | input | 1 | 1 = buffered mode, 0 = pass-through mode |
| cfg_thresh | input | 2 | Burst threshold select |
| cfg_msize | input | 2 | Memory width for pass-through mode |
| cnt_load | input | 1 | Loads the remaining count and empties the stream |
| cnt_init | input | CNT_W | Value loaded into the count |
| cnt | output | CNT_W | Remaining peripheral items |
| per_valid | input | 1 | Peripheral item offered |
| per_size | input | 2 | Size code of the offered item |
| per_data | input | 32 | Item data, right-aligned |
| per_ready | output | 1 | Item is taken on this clock if valid |
| mem_single | output | 1 | Single-transfer request (pass-through) |
| mem_burst_req | output | 1 | Burst request active |
| mem_beats_left | output | BLW | Words remaining in the current burst |
| mem_size | output | 2 | Size code of `mem_data` |
| mem_data | output | 32 | Data offered to memory |
| mem_ack | input | 1 | Memory takes the offered transfer or beat |
| err_flag | output | 1 | Sticky error flag |
| err_clr | input | 1 | Clears `err_flag` |

## Verification
Packing is tried with four bytes, with halfwords, with a byte-halfword-byte mix and with full words. These patterns separate wrong lane order, wrong pointer advance per size and wrong wrap of the store. Thresholds of 4, 8 and 16 bytes are driven with fills just below and exactly at the limit, which separates an early burst from a late one and checks the beat count. One stream ends on an exact multiple of the threshold and another leaves a residue, so the residue error is told apart from a plain end of stream. The discarded residue is confirmed by the data of the next stream. Pass-through mode is driven both with a matching width and with a mismatching one, the latter showing that dropped items neither reach memory nor consume count.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    localparam int DW    = 32;
    localparam int LANES = DW / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } dsf_size_e;

    function automatic logic [2:0] size_bytes(input logic [1:0] s);
        case (s)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

    function automatic logic [DW-1:0] size_mask(input logic [1:0] s);
        case (s)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dsf_count.sv
module dsf_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] init,
    input  logic         dec,
    output logic [W-1:0] cnt_q
);

    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = init;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/dsf_store.sv
module dsf_store
    import dsf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int FW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [2:0]    wr_nbytes,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_word,
    output logic [FW-1:0] fill
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [FW-1:0]         fill;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.wp   = '0;
            st_d.rp   = '0;
            st_d.fill = '0;
        end else begin
            if (wr_en) begin
                for (int i = 0; i < LANES; i++) begin
                    if (i < int'(wr_nbytes)) begin
                        st_d.mem[st_q.wp + PW'(i)] = wr_data[8*i +: 8];
                    end
                end
                st_d.wp = st_q.wp + PW'(wr_nbytes);
            end
            if (rd_en) begin
                st_d.rp = st_q.rp + PW'(LANES);
            end
            st_d.fill = st_q.fill
                      + (wr_en ? FW'(wr_nbytes) : FW'(0))
                      - (rd_en ? FW'(LANES)     : FW'(0));
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            rd_word[8*i +: 8] = st_q.mem[st_q.rp + PW'(i)];
        end
    end

    assign fill = st_q.fill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/dma_stream_fifo.sv
module dma_stream_fifo
    import dsf_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DEPTH_BYTES = 16,
    localparam int WORDS = DEPTH_BYTES / LANES,
    localparam int BLW   = $clog2(WORDS + 1),
    localparam int FW    = $clog2(DEPTH_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_fifo_en,
    input  logic [1:0]       cfg_thresh,
    input  logic [1:0]       cfg_msize,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_init,
    output logic [CNT_W-1:0] cnt,
    input  logic             per_valid,
    input  logic [1:0]       per_size,
    input  logic [31:0]      per_data,
    output logic             per_ready,
    output logic             mem_single,
    output logic             mem_burst_req,
    output logic [BLW-1:0]   mem_beats_left,
    output logic [1:0]       mem_size,
    output logic [31:0]      mem_data,
    input  logic             mem_ack,
    output logic             err_flag,
    input  logic             err_clr
);

    localparam int QUARTER = DEPTH_BYTES / 4;

    typedef struct packed {
        logic          hold_v;
        logic [DW-1:0] hold_data;
        logic [1:0]    hold_size;
        logic          burst;
        logic [BLW-1:0] beats;
        logic          err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [2:0]    nb;
    logic [FW-1:0] thr_bytes;
    logic [FW-1:0] st_fill;
    logic [DW-1:0] st_word;
    logic          acc, mismatch, cnt_dec, st_wr, st_rd, st_clr, resid;

    dsf_count #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .init  (cnt_init),
        .dec   (cnt_dec),
        .cnt_q (cnt)
    );

    dsf_store #(.DEPTH(DEPTH_BYTES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (st_clr),
        .wr_en     (st_wr),
        .wr_nbytes (nb),
        .wr_data   (per_data),
        .rd_en     (st_rd),
        .rd_word   (st_word),
        .fill      (st_fill)
    );

    always_comb begin
        nb        = size_bytes(per_size);
        thr_bytes = FW'((int'(cfg_thresh) + 1) * QUARTER);

        if (cfg_fifo_en) begin
            per_ready = (cnt != '0) && !cnt_load
                      && ((int'(st_fill) + int'(nb)) <= DEPTH_BYTES);
        end else begin
            per_ready = (cnt != '0) && !cnt_load && !ctl_q.hold_v;
        end

        acc      = per_valid && per_ready;
        mismatch = !cfg_fifo_en && (per_size != cfg_msize);
        cnt_dec  = acc && !mismatch;
        st_wr    = acc && cfg_fifo_en;
        st_rd    = ctl_q.burst && mem_ack;

        resid = cfg_fifo_en && !ctl_q.burst && (cnt == '0)
              && (st_fill != '0) && (st_fill < thr_bytes);
        st_clr = cnt_load || resid;

        ctl_d = ctl_q;

        if (ctl_q.hold_v && mem_ack) ctl_d.hold_v = 1'b0;
        if (acc && !cfg_fifo_en && !mismatch) begin
            ctl_d.hold_v    = 1'b1;
            ctl_d.hold_data = per_data & size_mask(per_size);
            ctl_d.hold_size = per_size;
        end

        if (ctl_q.burst) begin
            if (mem_ack) begin
                ctl_d.beats = ctl_q.beats - BLW'(1);
                if (ctl_q.beats == BLW'(1)) ctl_d.burst = 1'b0;
            end
        end else if (cfg_fifo_en && (st_fill >= thr_bytes)) begin
            ctl_d.burst = 1'b1;
            ctl_d.beats = BLW'(int'(cfg_thresh) + 1);
        end

        if (cnt_load) begin
            ctl_d.hold_v = 1'b0;
            ctl_d.burst  = 1'b0;
            ctl_d.beats  = '0;
        end

        if (err_clr) ctl_d.err = 1'b0;
        if ((acc && mismatch) || resid) ctl_d.err = 1'b1;
    end

    assign mem_single     = ctl_q.hold_v;
    assign mem_burst_req  = ctl_q.burst;
    assign mem_beats_left = ctl_q.beats;
    assign mem_data       = ctl_q.burst ? st_word : ctl_q.hold_data;
    assign mem_size       = ctl_q.burst ? 2'(SZ_WORD) : ctl_q.hold_size;
    assign err_flag       = ctl_q.err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/dsf_chk.sv
module dsf_chk #(
    parameter int CNT_W = 16,
    parameter int BLW   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_load,
    input logic [CNT_W-1:0] cnt,
    input logic             per_ready,
    input logic             mem_single,
    input logic             mem_burst_req,
    input logic [BLW-1:0]   mem_beats_left,
    input logic [31:0]      mem_data,
    input logic             mem_ack,
    input logic             err_flag,
    input logic             err_clr
);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_load |=> (($past(cnt) - cnt) <= CNT_W'(1)));

    assert_no_ready_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        per_ready |-> (cnt != '0));

    assert_single_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_single && !mem_ack && !cnt_load) |=> (mem_single && $stable(mem_data)));

    assert_req_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_single && mem_burst_req));

    assert_beats_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_burst_req && !mem_ack && !cnt_load) |=> (mem_burst_req && $stable(mem_beats_left)));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

endmodule

bind dma_stream_fifo dsf_chk #(.CNT_W(CNT_W), .BLW(BLW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cnt_load       (cnt_load),
    .cnt            (cnt),
    .per_ready      (per_ready),
    .mem_single     (mem_single),
    .mem_burst_req  (mem_burst_req),
    .mem_beats_left (mem_beats_left),
    .mem_data       (mem_data),
    .mem_ack        (mem_ack),
    .err_flag       (err_flag),
    .err_clr        (err_clr)
);

// File: tb/sim_dma_stream_fifo.sv
module sim_dma_stream_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fifo_en = 1'b0;
    logic [1:0]  cfg_thresh = 2'd0;
    logic [1:0]  cfg_msize = 2'd0;
    logic        cnt_load = 1'b0;
    logic [15:0] cnt_init = '0;
    logic [15:0] cnt;
    logic        per_valid = 1'b0;
    logic [1:0]  per_size = 2'd0;
    logic [31:0] per_data = '0;
    logic        per_ready;
    logic        mem_single, mem_burst_req;
    logic [2:0]  mem_beats_left;
    logic [1:0]  mem_size;
    logic [31:0] mem_data;
    logic        mem_ack = 1'b0;
    logic        err_flag;
    logic        err_clr = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dma_stream_fifo u0 (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_thresh(cfg_thresh),
        .cfg_msize(cfg_msize), .cnt_load(cnt_load), .cnt_init(cnt_init), .cnt(cnt),
        .per_valid(per_valid), .per_size(per_size), .per_data(per_data),
        .per_ready(per_ready), .mem_single(mem_single), .mem_burst_req(mem_burst_req),
        .mem_beats_left(mem_beats_left), .mem_size(mem_size), .mem_data(mem_data),
        .mem_ack(mem_ack), .err_flag(err_flag), .err_clr(err_clr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic load(input int n, input bit fifo, input logic [1:0] thr, input logic [1:0] msz);
        @(negedge clk);
        cfg_fifo_en = fifo; cfg_thresh = thr; cfg_msize = msz;
        cnt_init = 16'(n); cnt_load = 1'b1;
        @(negedge clk);
        cnt_load = 1'b0;
    endtask

    task automatic send(input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        per_valid = 1'b1; per_data = d; per_size = sz;
        for (int i = 0; i < 50; i++) begin
            #1;
            if (per_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        per_valid = 1'b0;
    endtask

    task automatic ack_once();
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
    endtask

    task automatic wait_burst();
        for (int i = 0; i < 8; i++) begin
            if (mem_burst_req) break;
            @(negedge clk);
        end
    endtask

    task automatic beat(input string tag, input logic [31:0] exp);
        check({tag, " burst req"}, 32'(mem_burst_req), 32'd1);
        check({tag, " beat data"}, mem_data, exp);
        ack_once();
    endtask

    task automatic t_reset();
        check("R1 cnt", 32'(cnt), 0);
        check("R1 per_ready", 32'(per_ready), 0);
        check("R1 mem_single", 32'(mem_single), 0);
        check("R1 burst", 32'(mem_burst_req), 0);
        check("R1 err", 32'(err_flag), 0);
    endtask

    task automatic t_direct();
        load(3, 0, 2'd0, 2'd0);
        check("R2 loaded", 32'(cnt), 3);
        send(32'h1234_5AA5, 2'd0);
        check("R4 single", 32'(mem_single), 1);
        check("R4 data masked", mem_data, 32'h0000_00A5);
        check("R4 size", 32'(mem_size), 0);
        check("R2 dec", 32'(cnt), 2);
        check("R4 ready low", 32'(per_ready), 0);
        repeat (2) @(negedge clk);
        check("R4 held", 32'(mem_single), 1);
        check("R4 held data", mem_data, 32'h0000_00A5);
        ack_once();
        check("R4 released", 32'(mem_single), 0);
        send(32'h0000_BEEF, 2'd1);
        check("R5 dropped", 32'(mem_single), 0);
        check("R5 err", 32'(err_flag), 1);
        check("R5 cnt kept", 32'(cnt), 2);
        repeat (3) @(negedge clk);
        check("R10 sticky", 32'(err_flag), 1);
        check("R2 idle hold", 32'(cnt), 2);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R10 cleared", 32'(err_flag), 0);
        send(32'h01, 2'd0); ack_once();
        send(32'h02, 2'd0); ack_once();
        check("R2 zero", 32'(cnt), 0);
        per_valid = 1'b1;
        #1;
        check("R3 ready at zero", 32'(per_ready), 0);
        per_valid = 1'b0;
    endtask

    task automatic t_bytes();
        load(8, 1, 2'd0, 2'd2);
        send(32'h11, 2'd0); send(32'h22, 2'd0); send(32'h33, 2'd0);
        @(negedge clk);
        check("R7 below quarter", 32'(mem_burst_req), 0);
        send(32'h44, 2'd0);
        wait_burst();
        check("R7 quarter len", 32'(mem_beats_left), 1);
        check("R11 burst size", 32'(mem_size), 2);
        beat("R6 bytes", 32'h4433_2211);
        check("R11 burst end", 32'(mem_burst_req), 0);
        send(32'h55, 2'd0); send(32'h66, 2'd0); send(32'h77, 2'd0); send(32'h88, 2'd0);
        wait_burst();
        beat("R6 bytes 2", 32'h8877_6655);
        @(negedge clk);
        check("R9 exact no err", 32'(err_flag), 0);
        check("R2 cnt done", 32'(cnt), 0);
    endtask

    task automatic t_halves();
        load(4, 1, 2'd1, 2'd2);
        send(32'hAABB, 2'd1); send(32'hCCDD, 2'd1);
        @(negedge clk);
        check("R7 below half", 32'(mem_burst_req), 0);
        send(32'h1122, 2'd1); send(32'h3344, 2'd1);
        wait_burst();
        check("R7 half len", 32'(mem_beats_left), 2);
        beat("R6 halves", 32'hCCDD_AABB);
        check("R11 beats dec", 32'(mem_beats_left), 1);
        beat("R11 second word", 32'h3344_1122);
        check("R11 burst end", 32'(mem_burst_req), 0);
    endtask

    task automatic t_mixed();
        load(3, 1, 2'd0, 2'd2);
        send(32'h0A, 2'd0); send(32'h0C0B, 2'd1); send(32'h0D, 2'd0);
        wait_burst();
        beat("R6 mixed", 32'h0D0C_0B0A);
    endtask

    task automatic t_full();
        load(5, 1, 2'd3, 2'd2);
        send(32'h1000_0000, 2'd2); send(32'h1000_0001, 2'd2);
        send(32'h1000_0002, 2'd2); send(32'h1000_0003, 2'd2);
        @(negedge clk);
        per_valid = 1'b1; per_data = 32'h1000_0004; per_size = 2'd2;
        #1;
        check("R8 full blocks", 32'(per_ready), 0);
        per_valid = 1'b0;
        wait_burst();
        check("R7 full len", 32'(mem_beats_left), 4);
        for (int k = 0; k < 4; k++) beat("R11 full order", 32'h1000_0000 + 32'(k));
        send(32'h1000_0004, 2'd2);
        @(negedge clk);
        check("R9 residue err", 32'(err_flag), 1);
        check("R9 no burst", 32'(mem_burst_req), 0);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        load(4, 1, 2'd0, 2'd2);
        send(32'h5A, 2'd0); send(32'h6B, 2'd0); send(32'h7C, 2'd0); send(32'h8D, 2'd0);
        wait_burst();
        beat("R9 residue discarded", 32'h8D7C_6B5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_bytes();
        t_halves();
        t_mixed();
        t_full();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule